// File: doc/BRIEF.md
# Dual Down-Counting Timer

This peripheral holds two independent 32-bit down-counters behind a small word-addressed register bus. Each counter decrements on a count tick. The tick comes either from a one-cycle reference pulse that the system provides synchronous to the bus clock, or from the bus clock divided by a power of two that software selects. A counter that reaches zero and then sees another tick raises a sticky event flag, and the flag drives that counter's interrupt line as a level. What happens next depends on the reload enable. With reload enabled, the counter takes its reload value and keeps running. With reload disabled, it switches itself off and stays at zero.

Software sets up periodic operation at period P by writing P-1 to both the reload and the current-value registers, then setting enable and reload enable together. A free-running up-count is built by writing all ones to both registers with reload enabled and reading the bitwise inverse of the current value. An event flag is acknowledged by writing a zero in its bit position of the status register. A one in that position leaves the flag as it is, so one channel can be acknowledged without disturbing the other.

Top module: `dual_down_timer`

## Requirements
- R1: After reset every register reads zero and both interrupt outputs are low.
- R2: Register offsets: control 0x00, status 0x04, reload 0x10 and current value 0x14 for counter 0, reload 0x18 and current value 0x1C for counter 1. A read of any other offset returns zero, and read data is zero while read enable is low.
- R3: Control bit positions: counter 0 uses enable bit 0, reload enable bit 1, reference-source bit 11 and prescale field bits 21..19. Counter 1 uses enable bit 2, reload enable bit 3, reference-source bit 12 and prescale field bits 24..22. All other control bits read as zero.
- R4: A write to a current-value register loads the counter at that clock edge, and the loaded value reads back on the next cycle. If a count tick falls in the same cycle as the write, the write takes priority.
- R5: With the reference-source bit clear and prescale field n, an enabled counter decrements once every 2^n bus cycles. The prescaler restarts when the counter is enabled, so m cycles after enabling, the counter has dropped by floor(m / 2^n).
- R6: With the reference-source bit set, an enabled counter decrements only in cycles where ref_tick is high, whatever its prescale field holds.
- R7: A counter whose enable bit is clear holds its value.
- R8: A tick that finds an enabled counter at zero sets its event flag. If reload enable is set, the counter then loads its reload value, which gives period P for a reload value of P-1.
- R9: When such an expiry happens with reload enable clear, the counter's enable bit clears itself and the value stays at zero.
- R10: Event flags sit in status bit 0 (counter 0) and bit 8 (counter 1). A status write clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. An expiry in the same cycle as a clearing write leaves the flag set.
- R11: irq[0] and irq[1] equal the event flags of counter 0 and counter 1 as levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle reference count pulse, synchronous to clk |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write enable for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read enable; read data is valid in the same cycle |
| bus_rdata | output | 32 | Read data, zero when not reading |
| irq | output | 2 | Per-counter interrupt level |

## Verification
Two functions can land on the same clock edge: hardware setting an event flag on expiry, and software clearing that same flag with a status write. The bench runs counter 0 periodically with a known period and counts cycles so that the clearing write meets the expiry edge exactly. It then checks that the flag reads back as set, and that a second clearing write one cycle later does clear it. A second collision, a current-value write landing on a running counter's tick, is judged by reading back the written value rather than that value minus one.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  localparam int NUM_CH   = 2;
  localparam int CTRL_OFS = 'h00;
  localparam int STAT_OFS = 'h04;

  // control field positions per channel
  function automatic int en_pos(int c);
    return 2 * c;
  endfunction

  function automatic int rld_pos(int c);
    return 2 * c + 1;
  endfunction

  function automatic int src_pos(int c);
    return 11 + c;
  endfunction

  function automatic int psc_pos(int c, int psc_w);
    return 19 + psc_w * c;
  endfunction

  // status flag position per channel
  function automatic int flag_pos(int c);
    return 8 * c;
  endfunction

  // per-channel register offsets
  function automatic int reload_ofs(int c);
    return 'h10 + 8 * c;
  endfunction

  function automatic int value_ofs(int c);
    return 'h14 + 8 * c;
  endfunction

  // writable control bits
  function automatic logic [31:0] ctrl_mask(int psc_w);
    logic [31:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      m[en_pos(c)]  = 1'b1;
      m[rld_pos(c)] = 1'b1;
      m[src_pos(c)] = 1'b1;
      for (int b = 0; b < psc_w; b++) m[psc_pos(c, psc_w) + b] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] shift,
  output logic             tick
);
  localparam int CNT_W = (1 << PSC_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  // last count of a 2^shift cycle period
  function automatic logic [CNT_W-1:0] period_last(logic [PSC_W-1:0] s);
    return CNT_W'((64'd1 << s) - 64'd1);
  endfunction

  assign limit = period_last(shift);
  assign tick  = run && (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel #(
  parameter int DATA_W = 32,
  parameter int PSC_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              reload_en,
  input  logic              use_ref,
  input  logic              ref_tick,
  input  logic [PSC_W-1:0]  shift,
  input  logic [DATA_W-1:0] reload_val,
  input  logic              val_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] value_q,
  output logic              tick,
  output logic              expire
);
  logic psc_tick;
  logic live_tick;

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .shift (shift),
    .tick  (psc_tick)
  );

  function automatic logic [DATA_W-1:0] step_down(logic [DATA_W-1:0] v);
    return v - DATA_W'(1);
  endfunction

  assign tick      = run && (use_ref ? ref_tick : psc_tick);
  assign live_tick = tick && !val_wr;
  assign expire    = live_tick && (value_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          value_q <= '0;
    else if (val_wr)     value_q <= wr_data;
    else if (expire)     value_q <= reload_en ? reload_val : value_q;
    else if (live_tick)  value_q <= step_down(value_q);
  end
endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PSC_W  = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic                           bus_we,
  input  logic [DATA_W-1:0]              bus_wdata,
  input  logic                           bus_re,
  output logic [DATA_W-1:0]              bus_rdata,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  ch_value,
  input  logic [NUM_CH-1:0]              ch_expire,
  output logic [DATA_W-1:0]              ctrl_q,
  output logic [NUM_CH-1:0]              flag_q,
  output logic [NUM_CH-1:0][DATA_W-1:0]  reload_q,
  output logic [NUM_CH-1:0]              val_wr,
  output logic                           ctrl_wr
);
  localparam logic [DATA_W-1:0] CMASK = DATA_W'(ctrl_mask(PSC_W));

  logic stat_wr;

  assign ctrl_wr = bus_we && (bus_addr == ADDR_W'(CTRL_OFS));
  assign stat_wr = bus_we && (bus_addr == ADDR_W'(STAT_OFS));

  // control: a software write wins over a one-shot self-disable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= bus_wdata & CMASK;
    end else begin
      for (int c = 0; c < NUM_CH; c++)
        if (ch_expire[c] && !ctrl_q[rld_pos(c)]) ctrl_q[en_pos(c)] <= 1'b0;
    end
  end

  // sticky flags: a zero written clears, a new expiry wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++)
        flag_q[c] <= ch_expire[c] |
                     (flag_q[c] & !(stat_wr && !bus_wdata[flag_pos(c)]));
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_regs
    logic rld_wr;
    assign rld_wr    = bus_we && (bus_addr == ADDR_W'(reload_ofs(c)));
    assign val_wr[c] = bus_we && (bus_addr == ADDR_W'(value_ofs(c)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reload_q[c] <= '0;
      else if (rld_wr) reload_q[c] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      if (bus_addr == ADDR_W'(CTRL_OFS)) bus_rdata = ctrl_q;
      if (bus_addr == ADDR_W'(STAT_OFS))
        for (int c = 0; c < NUM_CH; c++) bus_rdata[flag_pos(c)] = flag_q[c];
      for (int c = 0; c < NUM_CH; c++) begin
        if (bus_addr == ADDR_W'(reload_ofs(c))) bus_rdata = reload_q[c];
        if (bus_addr == ADDR_W'(value_ofs(c)))  bus_rdata = ch_value[c];
      end
    end
  end
endmodule

// File: rtl/dual_down_timer.sv
`timescale 1ns/1ps
module dual_down_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PSC_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  // named internal events, brought out for the checker
  logic [DATA_W-1:0]             ctrl_q;
  logic [NUM_CH-1:0]             ev_flag;
  logic [NUM_CH-1:0][DATA_W-1:0] ch_reload;
  logic [NUM_CH-1:0][DATA_W-1:0] ch_value;
  logic [NUM_CH-1:0]             ch_val_wr;
  logic [NUM_CH-1:0]             ch_en;
  logic [NUM_CH-1:0]             ch_rld;
  logic [NUM_CH-1:0]             ch_tick;
  logic [NUM_CH-1:0]             ch_expire;
  logic                          ctrl_wr;

  tmr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PSC_W(PSC_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .ch_value  (ch_value),
    .ch_expire (ch_expire),
    .ctrl_q    (ctrl_q),
    .flag_q    (ev_flag),
    .reload_q  (ch_reload),
    .val_wr    (ch_val_wr),
    .ctrl_wr   (ctrl_wr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_en[c]  = ctrl_q[en_pos(c)];
    assign ch_rld[c] = ctrl_q[rld_pos(c)];

    tmr_channel #(.DATA_W(DATA_W), .PSC_W(PSC_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (ch_en[c]),
      .reload_en  (ch_rld[c]),
      .use_ref    (ctrl_q[src_pos(c)]),
      .ref_tick   (ref_tick),
      .shift      (ctrl_q[psc_pos(c, PSC_W) +: PSC_W]),
      .reload_val (ch_reload[c]),
      .val_wr     (ch_val_wr[c]),
      .wr_data    (bus_wdata),
      .value_q    (ch_value[c]),
      .tick       (ch_tick[c]),
      .expire     (ch_expire[c])
    );
  end

  assign irq = ev_flag;
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_re,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [DATA_W-1:0]             bus_rdata,
  input logic [NUM_CH-1:0]             ch_en,
  input logic [NUM_CH-1:0]             ch_rld,
  input logic [NUM_CH-1:0]             ch_tick,
  input logic [NUM_CH-1:0]             ch_val_wr,
  input logic [NUM_CH-1:0]             ch_expire,
  input logic [NUM_CH-1:0]             ev_flag,
  input logic                          ctrl_wr,
  input logic [NUM_CH-1:0][DATA_W-1:0] ch_value,
  input logic [NUM_CH-1:0][DATA_W-1:0] ch_reload
);
  function automatic logic is_mapped(logic [ADDR_W-1:0] a);
    logic m;
    m = (a == ADDR_W'(CTRL_OFS)) || (a == ADDR_W'(STAT_OFS));
    for (int c = 0; c < NUM_CH; c++)
      m = m || (a == ADDR_W'(reload_ofs(c))) || (a == ADDR_W'(value_ofs(c)));
    return m;
  endfunction

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !is_mapped(bus_addr)) |-> bus_rdata == '0); // R2

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_en[c] && !ch_val_wr[c]) |=> $stable(ch_value[c])); // R7

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_tick[c] && !ch_val_wr[c] && ch_value[c] != '0)
        |=> ch_value[c] == $past(ch_value[c]) - DATA_W'(1)); // R5

    AST_WRITE_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_val_wr[c] && ch_tick[c]) |-> !ch_expire[c]); // R4

    AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_expire[c] && ch_rld[c]) |=> ch_value[c] == $past(ch_reload[c])); // R8

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_expire[c] && !ch_rld[c] && !ctrl_wr) |=> !ch_en[c] && ch_value[c] == '0); // R9

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ch_expire[c] |=> ev_flag[c]); // R10
  end
endmodule

bind dual_down_timer tmr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_re    (bus_re),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .ch_en     (ch_en),
  .ch_rld    (ch_rld),
  .ch_tick   (ch_tick),
  .ch_val_wr (ch_val_wr),
  .ch_expire (ch_expire),
  .ev_flag   (ev_flag),
  .ctrl_wr   (ctrl_wr),
  .ch_value  (ch_value),
  .ch_reload (ch_reload)
);

// File: tb/dual_down_timer_test.sv
`timescale 1ns/1ps
module dual_down_timer_test;
  localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04;
  localparam logic [7:0] A_RLD0 = 8'h10, A_VAL0 = 8'h14;
  localparam logic [7:0] A_RLD1 = 8'h18, A_VAL1 = 8'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  dual_down_timer uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  // expected encodings, restated from the requirements
  function automatic logic [31:0] ctl(bit en0, bit rl0, bit rf0, int n0,
                                      bit en1, bit rl1, bit rf1, int n1);
    logic [31:0] v;
    v = '0;
    v[0] = en0; v[1] = rl0; v[2] = en1; v[3] = rl1;
    v[11] = rf0; v[12] = rf1;
    v[21:19] = 3'(n0); v[24:22] = 3'(n1);
    return v;
  endfunction

  function automatic logic [31:0] drop_after(int cycles, int n);
    return 32'(cycles / (1 << n));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    #1;
    d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic expect_reg(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic cycles(int m);
    repeat (m) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", checks, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    int n, m, start, pulses;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    expect_reg("R1 ctrl", A_CTRL, 32'h0);
    expect_reg("R1 stat", A_STAT, 32'h0);
    expect_reg("R1 rld0", A_RLD0, 32'h0);
    expect_reg("R1 val1", A_VAL1, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);

    // R2: offsets, unmapped reads, idle read data
    wr(A_RLD1, 32'hA5A5_0001);
    wr(A_RLD0, 32'h0000_BEEF);
    expect_reg("R2 rld1", A_RLD1, 32'hA5A5_0001);
    expect_reg("R2 rld0", A_RLD0, 32'h0000_BEEF);
    expect_reg("R2 unmapped 08", 8'h08, 32'h0);
    expect_reg("R2 unmapped 20", 8'h20, 32'h0);
    bus_addr = A_RLD1; #1;
    check("R2 idle rdata", bus_rdata, 32'h0);

    // R3: control field mask (enable bits left clear)
    wr(A_CTRL, 32'hFFFF_FFF0);
    expect_reg("R3 ctrl mask", A_CTRL, ctl(0, 0, 1, 7, 0, 0, 1, 7));
    wr(A_CTRL, 32'h0);

    // R4: immediate load
    wr(A_VAL0, 32'h0000_1234);
    expect_reg("R4 load", A_VAL0, 32'h0000_1234);

    // R5: prescaled counting, random shifts and lengths
    for (int it = 0; it < 8; it++) begin
      n = (it < 2) ? it * 7 : int'($urandom_range(0, 7));
      m = int'($urandom_range(1, 300));
      start = int'($urandom_range(1000, 60000));
      wr(A_CTRL, 32'h0);
      wr(A_VAL0, 32'(start));
      wr(A_CTRL, ctl(1, 0, 0, n, 0, 0, 0, 0));
      cycles(m);
      expect_reg($sformatf("R5 psc n=%0d m=%0d", n, m), A_VAL0,
                 32'(start) - drop_after(m, n));
    end

    // R7: disabled counter holds
    wr(A_CTRL, 32'h0);
    rd(A_VAL0, d);
    cycles(25);
    expect_reg("R7 hold", A_VAL0, d);

    // R6: reference source, prescale field ignored
    wr(A_VAL1, 32'd5000);
    wr(A_CTRL, ctl(0, 0, 0, 0, 1, 0, 1, 0));
    pulses = 0;
    for (int i = 0; i < 120; i++) begin
      ref_tick = 1'($urandom_range(0, 1));
      if (ref_tick) pulses++;
      @(negedge clk);
    end
    ref_tick = 1'b0;
    expect_reg("R6 ref count", A_VAL1, 32'd5000 - 32'(pulses));
    wr(A_CTRL, ctl(0, 0, 0, 0, 1, 0, 1, 3));
    rd(A_VAL1, d);
    cycles(40);
    expect_reg("R6 no ref no count", A_VAL1, d);
    wr(A_CTRL, 32'h0);

    // R5: free-running up-count through the inverse
    wr(A_RLD0, 32'hFFFF_FFFF);
    wr(A_VAL0, 32'hFFFF_FFFF);
    wr(A_CTRL, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    cycles(37);
    rd(A_VAL0, d);
    check("R5 up-count", ~d, 32'd37);
    wr(A_CTRL, 32'h0);

    // R8/R11: periodic operation at period 6
    wr(A_STAT, 32'h0);
    wr(A_RLD0, 32'd5);
    wr(A_VAL0, 32'd5);
    wr(A_CTRL, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    cycles(5);
    expect_reg("R8 at zero", A_VAL0, 32'd0);
    expect_reg("R8 no flag yet", A_STAT, 32'h0);
    cycles(1);
    expect_reg("R8 reloaded", A_VAL0, 32'd5);
    expect_reg("R8 flag0", A_STAT, 32'h0000_0001);
    check("R11 irq0", 32'(irq), 32'h1);

    // R10: clearing write on the expiry edge leaves the flag set
    repeat (5) @(posedge clk);
    @(negedge clk);
    wr(A_STAT, 32'h0);
    expect_reg("R10 set wins", A_STAT, 32'h0000_0001);
    wr(A_STAT, 32'h0);
    expect_reg("R10 clear", A_STAT, 32'h0);
    check("R11 irq low", 32'(irq), 32'h0);

    // R4: value write on a running counter's tick
    wr(A_VAL0, 32'd300);
    expect_reg("R4 write over tick", A_VAL0, 32'd300);
    wr(A_CTRL, 32'h0);

    // R9: one-shot on counter 1
    wr(A_VAL1, 32'd3);
    wr(A_CTRL, ctl(0, 0, 0, 0, 1, 0, 0, 0));
    cycles(3);
    expect_reg("R9 still running", A_CTRL, ctl(0, 0, 0, 0, 1, 0, 0, 0));
    cycles(1);
    expect_reg("R9 self disable", A_CTRL, 32'h0);
    expect_reg("R10 flag1 bit8", A_STAT, 32'h0000_0100);
    check("R11 irq1", 32'(irq), 32'h2);
    cycles(10);
    expect_reg("R9 stays zero", A_VAL1, 32'h0);

    // R10: ones keep, zero in bit 8 clears only counter 1
    wr(A_STAT, 32'hFFFF_FFFF);
    expect_reg("R10 ones keep", A_STAT, 32'h0000_0100);
    wr(A_STAT, 32'hFFFF_FEFF);
    expect_reg("R10 bit8 clear", A_STAT, 32'h0);
    rd(A_VAL1, d2);
    check("R9 value after clear", d2, 32'h0);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule